// File: doc/BRIEF.md
# Column Burst Engine with Clock-Enable Suspend

This block is the column-access core of a synchronous DRAM device. Each rising edge it takes a decoded command (NOP, READ or WRITE) with a starting column. It walks the burst one column per internal cycle, writes or reads a small internal storage array, and returns read data on a DQ-style output after the programmed CAS latency. The output-enable signal models the pins going to high impedance when no read data is being returned.

A registered clock-enable input gates every internal edge. When `cke` is sampled low on a rising edge, the next internal edge is suspended. On a suspended edge no beat is issued, commands and write data are ignored, the latency pipeline stalls and the data already on the output stays driven. Burst length, ordering and the single-write mode bit are captured when a burst starts. `cas3` must be held steady while read data is in flight.

Top module: `colburst_engine`

## Requirements
- R1: After reset, `dq_oe` and `acc_vld` are both 0.
- R2: A READ (`cmd` = 2'b01) on an active edge starts a burst of L beats, with L = 1, 2, 4, 8 for `blen_code` = 0, 1, 2, 3. One beat is issued per active edge, starting at the command edge. `acc_vld` is 1 after each beat's edge and 0 after the first active edge that follows the last beat.
- R3: With `interleave` = 0, beat k of a burst starting at column S uses column (S & ~(L-1)) | ((S + k) & (L-1)), so the sequence wraps inside the aligned block. The column is shown on `acc_col`.
- R4: With `interleave` = 1, beat k uses column (S & ~(L-1)) | ((S ^ k) & (L-1)).
- R5: Count active edges from the READ edge as 0. The word read by the beat issued at active edge n appears on `dq_out` with `dq_oe` = 1 after active edge n + CL. CL is 2 when `cas3` = 0 and 3 when `cas3` = 1. Suspended edges do not count.
- R6: A WRITE (`cmd` = 2'b10) stores, for each beat, the `wdata` present at that beat's edge into that beat's column. Later reads return it.
- R7: With `single_write` = 1, a WRITE performs exactly one beat whatever `blen_code` is, and READs still use the full length L.
- R8: When `cke` is sampled 0 on a rising edge, the following edge is suspended. On that edge no beat is issued, `acc_vld` is 0, `acc_col` holds, the beat counter does not advance, and `cmd` and `wdata` are ignored.
- R9: On a suspended edge, `dq_out` and `dq_oe` keep their previous values.
- R10: When `cke` is sampled 1, the following edge is active, and an interrupted burst resumes with the beat after the last one issued.
- R11: A READ or WRITE on an active edge during a burst ends that burst and starts beat 0 at the new column. Read beats already issued are still delivered.
- R12: On the first active edge after the last read word has been output, `dq_oe` returns to 0 and the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable, registered; 0 suspends the following edge |
| cmd | input | 2 | 00 NOP, 01 READ, 10 WRITE, 11 treated as NOP |
| col | input | COL_W | Starting column for READ or WRITE |
| blen_code | input | 2 | Burst length 1, 2, 4, 8 for codes 0 to 3 |
| interleave | input | 1 | 0 sequential wrap, 1 interleaved order |
| cas3 | input | 1 | 0 selects latency 2, 1 selects latency 3 |
| single_write | input | 1 | 1 makes every WRITE a single beat |
| wdata | input | DW | Write data for the current beat |
| acc_vld | output | 1 | A beat was issued on the last edge |
| acc_col | output | COL_W | Column of the last issued beat |
| dq_out | output | DW | Read data output |
| dq_oe | output | 1 | Read data driven; 0 models high impedance |

## Verification
The hardest state to reach is a suspension that lands in the middle of a burst while read words are still inside the latency pipeline. There the engine must hold the beat counter, the pipeline and the driven word all at once, and then pick up at the right beat. The bench drives `cke` from a per-slot bit pattern, so suspended edges can fall before, between or after beats, at either latency. It keeps its own count of active edges and predicts every column and data word from that count. On suspended slots it presents decoy commands and decoy write data, which later full-array reads would expose if they had been taken.

// File: rtl/colburst_pkg.sv
package colburst_pkg;

  // Width of the in-burst beat index; longest burst is 2**BEAT_W beats.
  localparam int BEAT_W = 3;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_SPARE = 2'b11
  } cmd_e;

  // Offset mask for a burst-length code: 1, 2, 4 or 8 beats.
  function automatic logic [BEAT_W-1:0] len_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 3'b000;
      2'd1:    return 3'b001;
      2'd2:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/colburst_seq.sv
module colburst_seq
  import colburst_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic [COL_W-1:0]  base,
  input  logic [BEAT_W-1:0] idx,
  input  logic [BEAT_W-1:0] mask,
  input  logic              ileave,
  output logic [COL_W-1:0]  col
);

  logic [BEAT_W-1:0] off;
  logic [COL_W-1:0]  m_ext;

  always_comb begin
    off   = ileave ? (base[BEAT_W-1:0] ^ idx) : (base[BEAT_W-1:0] + idx);
    m_ext = COL_W'(mask);
    col   = (base & ~m_ext) | (COL_W'(off) & m_ext);
  end

endmodule

// File: rtl/colburst_ctrl.sv
module colburst_ctrl
  import colburst_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] col,
  input  logic [1:0]       blen_code,
  input  logic             ileave,
  input  logic             single_write,
  output logic             issue,
  output logic             issue_wr,
  output logic [COL_W-1:0] issue_col
);

  cmd_e              op;
  logic              busy, cur_wr, cur_il;
  logic [COL_W-1:0]  cur_base;
  logic [BEAT_W-1:0] cur_idx, cur_mask;

  logic              is_rd, is_wr, start, cont, seq_il;
  logic [BEAT_W-1:0] new_mask, seq_idx, seq_mask;
  logic [COL_W-1:0]  seq_base;

  assign op = cmd_e'(cmd);

  always_comb begin
    is_rd    = (op == CMD_READ);
    is_wr    = (op == CMD_WRITE);
    start    = en & (is_rd | is_wr);
    cont     = en & busy & (cur_idx != cur_mask);
    new_mask = (is_wr & single_write) ? '0 : len_mask(blen_code);
    if (start) begin
      seq_base = col;
      seq_idx  = '0;
      seq_mask = new_mask;
      seq_il   = ileave;
    end else begin
      seq_base = cur_base;
      seq_idx  = cur_idx + 1'b1;
      seq_mask = cur_mask;
      seq_il   = cur_il;
    end
    issue    = start | cont;
    issue_wr = start ? is_wr : cur_wr;
  end

  colburst_seq #(.COL_W(COL_W)) u_seq (
    .base   (seq_base),
    .idx    (seq_idx),
    .mask   (seq_mask),
    .ileave (seq_il),
    .col    (issue_col)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur_wr   <= 1'b0;
      cur_il   <= 1'b0;
      cur_base <= '0;
      cur_idx  <= '0;
      cur_mask <= '0;
    end else if (en) begin
      if (start) begin
        busy     <= 1'b1;
        cur_wr   <= is_wr;
        cur_il   <= ileave;
        cur_base <= col;
        cur_idx  <= '0;
        cur_mask <= new_mask;
      end else if (cont) begin
        cur_idx <= cur_idx + 1'b1;
      end else begin
        busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/colburst_array.sv
module colburst_array #(
  parameter int COL_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [COL_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);

  localparam int DEPTH = 1 << COL_W;

  logic [DW-1:0] mem [DEPTH];

  // Single port with a registered read: maps onto a block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/colburst_latency.sv
module colburst_latency #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          issue_rd,
  input  logic [DW-1:0] arr_q,
  input  logic          cas3,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe
);

  // Stage 0 is the array's own read register; latency 3 needs two more.
  localparam int STAGES = 3;

  logic [STAGES-1:0] vld;
  logic [DW-1:0]     dat [1:STAGES-1];
  int unsigned       tap;

  assign tap = cas3 ? 2 : 1;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (en) vld <= {vld[STAGES-2:0], issue_rd};
  end

  always_ff @(posedge clk) begin
    if (en) begin
      dat[1] <= arr_q;
      for (int i = 2; i < STAGES; i++) dat[i] <= dat[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else if (en) begin
      dq_oe  <= vld[tap];
      dq_out <= dat[tap];
    end
  end

endmodule

// File: rtl/colburst_engine.sv
module colburst_engine #(
  parameter int COL_W = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] col,
  input  logic [1:0]       blen_code,
  input  logic             interleave,
  input  logic             cas3,
  input  logic             single_write,
  input  logic [DW-1:0]    wdata,
  output logic             acc_vld,
  output logic [COL_W-1:0] acc_col,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);

  logic             cke_q, en;
  logic             issue, issue_wr;
  logic [COL_W-1:0] issue_col;
  logic [DW-1:0]    arr_q;
  logic             arr_we, arr_re;

  // The enable register itself is never frozen.
  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  assign en     = cke_q;
  assign arr_we = en & issue & issue_wr;
  assign arr_re = en & issue & ~issue_wr;

  colburst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .cmd          (cmd),
    .col          (col),
    .blen_code    (blen_code),
    .ileave       (interleave),
    .single_write (single_write),
    .issue        (issue),
    .issue_wr     (issue_wr),
    .issue_col    (issue_col)
  );

  colburst_array #(.COL_W(COL_W), .DW(DW)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .re    (arr_re),
    .addr  (issue_col),
    .wdata (wdata),
    .rdata (arr_q)
  );

  colburst_latency #(.DW(DW)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .issue_rd (arr_re),
    .arr_q    (arr_q),
    .cas3     (cas3),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_vld <= 1'b0;
      acc_col <= '0;
    end else begin
      acc_vld <= en & issue;
      if (en & issue) acc_col <= issue_col;
    end
  end

endmodule

// File: rtl/colburst_chk.sv
module colburst_chk #(
  parameter int COL_W = 4,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cke,
  input logic             acc_vld,
  input logic [COL_W-1:0] acc_col,
  input logic [DW-1:0]    dq_out,
  input logic             dq_oe
);

  logic ck1, ck2, seen_acc;

  // ck2 at a sample holds cke as seen two edges earlier: 0 means the
  // edge just past was suspended.
  always_ff @(posedge clk) begin
    if (rst) begin
      ck1      <= 1'b1;
      ck2      <= 1'b1;
      seen_acc <= 1'b0;
    end else begin
      ck1 <= cke;
      ck2 <= ck1;
      if (acc_vld) seen_acc <= 1'b1;
    end
  end

  assert_no_beat_suspended_R8: assert property (@(posedge clk) disable iff (rst)
    !ck2 |-> !acc_vld);

  assert_col_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !ck2 |-> $stable(acc_col));

  assert_dq_held_R9: assert property (@(posedge clk) disable iff (rst)
    !ck2 |-> ($stable(dq_out) && $stable(dq_oe)));

  assert_oe_after_access_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> seen_acc);

endmodule

bind colburst_engine colburst_chk #(.COL_W(COL_W), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cke     (cke),
  .acc_vld (acc_vld),
  .acc_col (acc_col),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe)
);

// File: tb/sim_colburst_engine.sv
`timescale 1ns/1ps
module sim_colburst_engine;

  localparam int COL_W = 4;
  localparam int DW    = 16;
  localparam logic [31:0] ALL_ON = 32'hFFFF_FFFF;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cke = 1'b1;
  logic [1:0]       cmd = 2'b00;
  logic [COL_W-1:0] col = '0;
  logic [1:0]       blen_code = 2'd0;
  logic             interleave = 1'b0;
  logic             cas3 = 1'b0;
  logic             single_write = 1'b0;
  logic [DW-1:0]    wdata = '0;
  logic             acc_vld;
  logic [COL_W-1:0] acc_col;
  logic [DW-1:0]    dq_out;
  logic             dq_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] ref_mem [16];
  int seed_n = 1;

  always #2.5 clk = ~clk;

  colburst_engine #(.COL_W(COL_W), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .col(col),
    .blen_code(blen_code), .interleave(interleave), .cas3(cas3),
    .single_write(single_write), .wdata(wdata),
    .acc_vld(acc_vld), .acc_col(acc_col), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] seqcol(input logic [3:0] s, input int k, input int len, input bit il);
    int m, off;
    m   = len - 1;
    off = il ? (int'(s) ^ k) : (int'(s) + k);
    return 4'((int'(s) & ~m) | (off & m));
  endfunction

  function automatic logic [DW-1:0] pattern(input int seed, input int c);
    return DW'((seed * 4099 + c * 257) ^ 16'h5A3C);
  endfunction

  // Read burst with optional interrupting READ at active-edge index islot.
  task automatic run_read(input logic [3:0] s, input int code, input bit il,
                          input int islot, input logic [3:0] s2, input logic [31:0] pat);
    int len, cl, total, n;
    bit en_e, prev_susp, v, exp_oe;
    logic [3:0] c;
    logic [3:0] issued [64];
    logic [DW-1:0] prev_dq;
    logic prev_oe;
    len = 1 << code;
    cl = cas3 ? 3 : 2;
    total = (islot > 0) ? islot + len : len;
    n = 0;
    prev_susp = 1'b0;
    prev_dq = dq_out;
    prev_oe = dq_oe;
    blen_code = 2'(code);
    interleave = il;
    for (int j = 0; j < 64 && n <= total + cl; j++) begin
      en_e = (j == 0) ? 1'b1 : pat[(j-1) % 32];
      cke = (j < 32) ? pat[j] : 1'b1;
      if (en_e) begin
        wdata = '0;
        if (n == 0) begin cmd = 2'b01; col = s; end
        else if (islot > 0 && n == islot) begin cmd = 2'b01; col = s2; end
        else cmd = 2'b00;
      end else begin
        cmd = 2'b10; col = 4'hF; wdata = 16'hDEAD;
      end
      @(negedge clk);
      if (en_e) begin
        if (islot > 0 && n >= islot) begin
          v = (n - islot) < len;
          c = seqcol(s2, n - islot, len, il);
        end else begin
          v = n < len;
          c = seqcol(s, n, len, il);
        end
        if (v) issued[n] = c;
        check(acc_vld == v, single_write ? "R7 read length" :
              (prev_susp ? "R10 resume beat" : "R2 beat valid"), acc_vld, v);
        if (v) check(acc_col == c, (islot > 0 && n >= islot) ? "R11 new column" :
                     (prev_susp ? "R10 resume column" : (il ? "R4 interleaved" : "R3 sequential")),
                     acc_col, c);
        exp_oe = (n >= cl) && (n - cl < total);
        check(dq_oe == exp_oe, exp_oe ? "R5 oe" : "R12 oe low", dq_oe, exp_oe);
        if (exp_oe) check(dq_out == ref_mem[issued[n-cl]], "R5 read data", dq_out, ref_mem[issued[n-cl]]);
        n++;
      end else begin
        check(acc_vld == 1'b0, "R8 no beat", acc_vld, 0);
        check(dq_out == prev_dq && dq_oe == prev_oe, "R9 dq held", {dq_oe, dq_out}, {prev_oe, prev_dq});
      end
      prev_susp = !en_e;
      prev_dq = dq_out;
      prev_oe = dq_oe;
    end
    cke = 1'b1; cmd = 2'b00; wdata = '0;
    @(negedge clk);
  endtask

  task automatic run_write(input logic [3:0] s, input int code, input bit il,
                           input int seed, input logic [31:0] pat);
    int len, lw, n;
    bit en_e, v, prev_susp;
    logic [3:0] c;
    len = 1 << code;
    lw = single_write ? 1 : len;
    n = 0;
    prev_susp = 1'b0;
    blen_code = 2'(code);
    interleave = il;
    for (int j = 0; j < 64 && n <= lw; j++) begin
      en_e = (j == 0) ? 1'b1 : pat[(j-1) % 32];
      cke = (j < 32) ? pat[j] : 1'b1;
      if (en_e) begin
        cmd = (n == 0) ? 2'b10 : 2'b00;
        col = s;
        wdata = (n < lw) ? pattern(seed, seqcol(s, n, len, il)) : '0;
      end else begin
        cmd = 2'b01; col = 4'hF; wdata = 16'hBEEF;
      end
      @(negedge clk);
      if (en_e) begin
        v = n < lw;
        c = seqcol(s, n, len, il);
        check(acc_vld == v, single_write ? "R7 single write" :
              (prev_susp ? "R10 resume write" : "R6 write beat"), acc_vld, v);
        if (v) begin
          check(acc_col == c, "R6 write column", acc_col, c);
          ref_mem[c] = pattern(seed, c);
        end
        check(dq_oe == 1'b0, "R6 no read data", dq_oe, 0);
        n++;
      end else begin
        check(acc_vld == 1'b0, "R8 write suspended", acc_vld, 0);
        check(dq_oe == 1'b0, "R8 junk read ignored", dq_oe, 0);
      end
      prev_susp = !en_e;
    end
    cke = 1'b1; cmd = 2'b00; wdata = '0;
    @(negedge clk);
  endtask

  task automatic verify_all();
    run_read(4'd0, 3, 1'b0, 0, 4'd0, ALL_ON);
    run_read(4'd8, 3, 1'b0, 0, 4'd0, ALL_ON);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dq_oe == 1'b0, "R1 oe after reset", dq_oe, 0);
    check(acc_vld == 1'b0, "R1 acc_vld after reset", acc_vld, 0);

    // Fill the whole array with full-length bursts (R6).
    run_write(4'd0, 3, 1'b0, seed_n, ALL_ON); seed_n++;
    run_write(4'd8, 3, 1'b0, seed_n, ALL_ON); seed_n++;

    // Exhaustive read sweep: latency, length, order, start column.
    // Single-write mode is on during the latency-3 half (R7: reads keep L).
    for (int lt = 0; lt < 2; lt++) begin
      cas3 = lt[0];
      single_write = lt[0];
      for (int code = 0; code < 4; code++)
        for (int il = 0; il < 2; il++)
          for (int s = 0; s < 16; s++)
            run_read(4'(s), code, il[0], 0, 4'd0, ALL_ON);
    end

    // Write sweep in both write modes, each checked by full readback (R6, R7).
    cas3 = 1'b0;
    for (int sw = 0; sw < 2; sw++) begin
      single_write = sw[0];
      for (int code = 0; code < 4; code++)
        for (int il = 0; il < 2; il++)
          for (int si = 0; si < 3; si++) begin
            run_write(4'((si * 11) % 16), code, il[0], seed_n, ALL_ON);
            seed_n++;
            verify_all();
          end
    end
    single_write = 1'b0;

    // Suspension during reads and writes at both latencies (R8, R9, R10).
    for (int lt = 0; lt < 2; lt++) begin
      cas3 = lt[0];
      run_read(4'd2, 2, 1'b0, 0, 4'd0, 32'hFFFF_FFF9);
      run_read(4'd13, 3, 1'b1, 0, 4'd0, 32'hFFFF_6DB5);
      run_read(4'd6, 3, 1'b0, 0, 4'd0, 32'hFFFF_F0FD);
      run_read(4'd9, 0, 1'b0, 0, 4'd0, 32'hFFFF_FFFA);
      run_write(4'd5, 3, 1'b1, seed_n, 32'hFFFF_FEED); seed_n++;
      run_write(4'd10, 2, 1'b0, seed_n, 32'hFFFF_FF9B); seed_n++;
      verify_all();
    end

    // Interrupting bursts with a new READ (R11).
    cas3 = 1'b0;
    run_read(4'd3, 3, 1'b0, 2, 4'd12, ALL_ON);
    cas3 = 1'b1;
    run_read(4'd7, 3, 1'b1, 5, 4'd1, ALL_ON);
    run_read(4'd4, 2, 1'b0, 1, 4'd14, 32'hFFFF_FFF5);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule